// File: doc/BRIEF.md
# PLL Handoff and System Clock Divider

This block decides whether the system clock is taken from the main clock or from the PLL output, and it produces a divided system-clock enable from the chosen source. It holds three software-visible fields behind a small register bus: a PLL power-down bit, a high-frequency select bit and a multiplication-mode field. The mode field picks a multiply of x3, x4 or x5 of the 12 MHz main clock. A lock timer inside the block stands in for the PLL settling time. It counts main-clock cycles once the PLL is powered up.

Software brings the PLL in with three writes, in this order: set the mode, clear the power-down bit, then clear the select bit. A clear of the select bit is refused until the PLL has locked, so software keeps writing the clear and reading the bit back until it reads 0. Writing the select bit to 1 returns the system to the main clock. Setting the power-down bit drops lock at once and forces the main clock. The mode field cannot change while the PLL drives the system clock.

The divider gives one enable pulse every D+1 source cycles, where D is a 4-bit field. A new D takes effect only when the current divide period ends. The block has no data stream. Every pin is a plain control or status signal, and a write is accepted on any cycle in which `wr_en` is high, so there is no back-pressure.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset, register 0 reads 3 (select bit = 1, main clock; power-down = 1; locked = 0), register 1 reads 0 (x3), register 2 reads 0 (divide by 1), `src_pll` = 0, and `sys_clk_en` is high on every cycle.
- R2: Register 1 bits [1:0] hold the mode: 0 = x3, 1 = x4, 2 = x5. The field drives `pll_mode`. A write of value 3 is ignored.
- R3: While `src_pll` = 1, writes to register 1 are ignored. After a return to the main clock, the same write is accepted.
- R4: A write to register 0 with bit 0 = 0 leaves the select bit at 1 if the PLL is powered down or not locked.
- R5: `pll_locked` (and register 0 bit 2) goes high exactly LOCK_CYCLES clock cycles after the write that clears power-down (register 0 bit 1). It is never high while power-down is set.
- R6: Once locked, a write to register 0 with bits [1:0] = 0 clears the select bit. `src_pll` then rises and register 0 reads 4.
- R7: A write to register 0 with bit 0 = 1 returns `src_pll` to 0 on the next cycle.
- R8: A write to register 0 with bit 1 = 1 sets power-down, clears `pll_locked` and `src_pll` at once, and sets the select bit.
- R9: Register 2 bits [3:0] = D makes `sys_clk_en` pulse once every D+1 cycles, for D from 0 to 15. Bits [7:4] are ignored.
- R10: A change of D takes effect only after the current divide period has ended at its terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read (0 control, 1 mode, 2 divider) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| src_pll | output | 1 | 1 when the PLL drives the system clock |
| pll_pwrdn | output | 1 | PLL power-down control |
| pll_mode | output | 2 | PLL multiply mode |
| pll_locked | output | 1 | Lock timer has expired |
| sys_clk_en | output | 1 | Divided system-clock enable |

## Verification
The assertions assume that `addr` and `wr_data` are stable and known whenever `wr_en` is high. They also assume that the only way to lose lock is through the power-down bit, because no external lock input exists. The bench changes inputs only at falling edges and holds each write for exactly one rising edge. Its lock-wait loops read register 0 back through the normal bus rather than watching internal state. The lock time is shortened by parameter, so the whole handoff sequence fits in a short run.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 4;
  localparam int MODE_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_MODE = 2'd1,
    REG_DIV  = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic [MODE_W-1:0] {
    MUL_X3  = 2'd0,
    MUL_X4  = 2'd1,
    MUL_X5  = 2'd2,
    MUL_BAD = 2'd3
  } mul_mode_e;

  localparam int CTRL_SEL_BIT  = 0;
  localparam int CTRL_PWDN_BIT = 1;
  localparam int CTRL_LOCK_BIT = 2;
endpackage

// File: rtl/sysclk_lock_timer.sv
module sysclk_lock_timer #(
  parameter int LOCK_CYCLES = 4800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrdn,
  output logic locked
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOCK_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || pwrdn) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Lock falls in the same cycle that power-down is set.
  assign locked = !pwrdn && (cnt_q == LIMIT);
endmodule

// File: rtl/sysclk_regs.sv
module sysclk_regs
  import sysclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              locked,
  output logic              sel_main,
  output logic              pwrdn,
  output logic [MODE_W-1:0] mode,
  output logic [DIV_W-1:0]  div
);
  logic ctrl_wr, mode_wr, div_wr;
  logic want_pwdn, want_main;

  assign ctrl_wr   = wr_en && (reg_addr_e'(addr) == REG_CTRL);
  assign mode_wr   = wr_en && (reg_addr_e'(addr) == REG_MODE);
  assign div_wr    = wr_en && (reg_addr_e'(addr) == REG_DIV);
  assign want_pwdn = wr_data[CTRL_PWDN_BIT];
  assign want_main = wr_data[CTRL_SEL_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_main <= 1'b1;
      pwrdn    <= 1'b1;
    end else if (ctrl_wr) begin
      pwrdn <= want_pwdn;
      if (want_pwdn || want_main) begin
        sel_main <= 1'b1;
      end else if (locked) begin
        sel_main <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MUL_X3;
    end else if (mode_wr && sel_main &&
                 (mul_mode_e'(wr_data[MODE_W-1:0]) != MUL_BAD)) begin
      mode <= wr_data[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div <= '0;
    end else if (div_wr) begin
      div <= wr_data[DIV_W-1:0];
    end
  end
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ratio,
  output logic         tick
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] act_q;

  assign tick = (cnt_q == act_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
      act_q <= ratio;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int LOCK_CYCLES = 4800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              src_pll,
  output logic              pll_pwrdn,
  output logic [MODE_W-1:0] pll_mode,
  output logic              pll_locked,
  output logic              sys_clk_en
);
  logic             sel_main;
  logic [DIV_W-1:0] div_field;

  sysclk_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwrdn  (pll_pwrdn),
    .locked (pll_locked)
  );

  sysclk_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .locked   (pll_locked),
    .sel_main (sel_main),
    .pwrdn    (pll_pwrdn),
    .mode     (pll_mode),
    .div      (div_field)
  );

  sysclk_divider #(.W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .ratio (div_field),
    .tick  (sys_clk_en)
  );

  assign src_pll = !sel_main;

  always_comb begin
    rd_data = '0;
    unique case (reg_addr_e'(addr))
      REG_CTRL: begin
        rd_data[CTRL_SEL_BIT]  = sel_main;
        rd_data[CTRL_PWDN_BIT] = pll_pwrdn;
        rd_data[CTRL_LOCK_BIT] = pll_locked;
      end
      REG_MODE: rd_data[MODE_W-1:0] = pll_mode;
      REG_DIV:  rd_data[DIV_W-1:0]  = div_field;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sysclk_ctrl_checker.sv
module sysclk_ctrl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       src_pll,
  input logic       pll_pwrdn,
  input logic [1:0] pll_mode,
  input logic       pll_locked,
  input logic       sys_clk_en
);
  logic [4:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n || sys_clk_en) begin
      gap_q <= '0;
    end else if (gap_q != 5'd31) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    pll_mode != 2'd3);

  a_r3_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(src_pll) |-> $stable(pll_mode));

  a_r4_switch_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_pll) |-> $past(pll_locked));

  a_r5_lock_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    pll_locked |-> !pll_pwrdn);

  a_r8_pwrdn_forces_main: assert property (@(posedge clk) disable iff (!rst_n)
    pll_pwrdn |-> !src_pll);

  a_r9_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_clk_en |-> (gap_q < 5'd15));
endmodule

bind sysclk_ctrl sysclk_ctrl_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_pll    (src_pll),
  .pll_pwrdn  (pll_pwrdn),
  .pll_mode   (pll_mode),
  .pll_locked (pll_locked),
  .sys_clk_en (sys_clk_en)
);

// File: tb/sysclk_ctrl_bench.sv
`timescale 1ns/1ps
module sysclk_ctrl_bench;
  localparam int LOCK = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       src_pll, pll_pwrdn, pll_locked, sys_clk_en;
  logic [1:0] pll_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sysclk_ctrl #(.LOCK_CYCLES(LOCK)) u_sysclk_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .src_pll(src_pll), .pll_pwrdn(pll_pwrdn),
    .pll_mode(pll_mode), .pll_locked(pll_locked), .sys_clk_en(sys_clk_en)
  );

  // {addr, data, expected ctrl, expected mode, expected div}
  typedef struct packed {
    logic [1:0] a;
    logic [7:0] d;
    logic [7:0] ec;
    logic [7:0] em;
    logic [7:0] ed;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{2'd1, 8'h01, 8'h03, 8'h01, 8'h00},  // R2 x4
    '{2'd1, 8'h02, 8'h03, 8'h02, 8'h00},  // R2 x5
    '{2'd1, 8'h03, 8'h03, 8'h02, 8'h00},  // R2 value 3 ignored
    '{2'd2, 8'h05, 8'h03, 8'h02, 8'h05},  // R9
    '{2'd2, 8'hF7, 8'h03, 8'h02, 8'h07},  // R9 upper bits ignored
    '{2'd0, 8'h00, 8'h01, 8'h02, 8'h07},  // R4 not locked
    '{2'd0, 8'h02, 8'h03, 8'h02, 8'h07},  // R4 powered down
    '{2'd1, 8'h00, 8'h03, 8'h00, 8'h07},  // R2 x3
    '{2'd2, 8'h00, 8'h03, 8'h00, 8'h00}   // R9 back to /1
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic gap(output int n);
    n = 0;
    while (!sys_clk_en) @(negedge clk);
    @(negedge clk);
    n = 1;
    while (!sys_clk_en) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 3);
    rd(2'd1, v); check("R1 mode", v, 0);
    rd(2'd2, v); check("R1 div", v, 0);
    check("R1 src_pll", src_pll, 0);
    for (int i = 0; i < 4; i++) begin
      check("R1 clk_en", sys_clk_en, 1);
      @(negedge clk);
    end

    // Table walk
    for (int i = 0; i < 9; i++) begin
      wr(VECS[i].a, VECS[i].d);
      rd(2'd0, v); check("R4 vec ctrl", v, VECS[i].ec);
      rd(2'd1, v); check("R2 vec mode", v, VECS[i].em);
      check("R2 vec pll_mode", pll_mode, VECS[i].em[1:0]);
      rd(2'd2, v); check("R9 vec div", v, VECS[i].ed);
    end

    // R5 lock timing
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h01);
    repeat (LOCK - 1) @(negedge clk);
    check("R5 not yet locked", pll_locked, 0);
    wr(2'd0, 8'h00);
    check("R4 early clear ignored", src_pll, 0);
    check("R5 locked", pll_locked, 1);

    // R6 handoff with retry loop
    n = 0;
    do begin
      wr(2'd0, 8'h00);
      rd(2'd0, v);
      n++;
    end while (v[0] && n < 50);
    check("R6 ctrl", v, 4);
    check("R6 src_pll", src_pll, 1);

    // R3 mode frozen
    wr(2'd1, 8'h02);
    rd(2'd1, v); check("R3 mode frozen", v, 1);

    // R7 back to main
    wr(2'd0, 8'h01);
    check("R7 src_pll", src_pll, 0);
    wr(2'd1, 8'h02);
    rd(2'd1, v); check("R3 mode accepted", v, 2);

    // R8 power-down while on PLL
    wr(2'd0, 8'h00);
    check("R8 on pll", src_pll, 1);
    addr = 2'd0; wr_data = 8'h02; wr_en = 1'b1;
    @(posedge clk); #1;
    check("R8 locked drop", pll_locked, 0);
    check("R8 src main", src_pll, 0);
    @(negedge clk); wr_en = 1'b0;
    rd(2'd0, v); check("R8 ctrl", v, 3);

    // R9 divide ratios
    wr(2'd2, 8'h03);
    repeat (20) @(negedge clk);
    gap(n); check("R9 div4", n, 4);
    wr(2'd2, 8'h0F);
    repeat (40) @(negedge clk);
    gap(n); check("R9 div16", n, 16);

    // R10 change at terminal count
    while (!sys_clk_en) @(negedge clk);
    wr(2'd2, 8'h00);
    n = 1;
    while (!sys_clk_en) begin
      @(negedge clk);
      n++;
    end
    check("R10 old period kept", n, 16);
    @(negedge clk);
    check("R10 new ratio", sys_clk_en, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule